// File: doc/BRIEF.md
# Stream-to-Memory DMA Write Channel

This block is the write half of a simple-mode DMA engine. It takes a 32-bit valid/ready data stream and stores each beat as one word at consecutive memory addresses. Software uses a small register port to set a run bit, a destination address and a byte length. The write to the length register is what launches a transfer. The memory side is a plain one-word request/acknowledge port, and each request carries one address and one data word.

A four-entry holding buffer sits between the stream and the memory writer. Out of reset, before any transfer has been programmed, the channel takes four beats and then holds its ready output low. Those beats are not discarded. When software arms a transfer, ready rises again and the held beats become the first words written. After a transfer completes, the buffer again fills to four entries while the channel is idle. Those beats lead the next transfer.

Top module: `s2mm_write_channel`

## Requirements
- R1: While no transfer is armed, the channel accepts stream beats until its holding buffer contains four. It then keeps `s_ready` low for as long as no transfer is armed, whatever `s_valid` does.
- R2: Register map: control at offset 0x30 with bit 0 as the run bit; status at 0x34 with bit 0 = busy and bit 1 = done; destination at 0x48; length in bytes at 0x58. A write takes effect at the clock edge where `reg_wr_en` is high. `reg_rdata` returns the addressed register combinationally. The destination reads back with its two low bits cleared, and an unmapped offset reads 0.
- R3: A length write arms a transfer of length/4 words and sets busy, but only when the run bit is 1, busy is 0 and length/4 is nonzero. Any other length write is ignored and leaves both the length register and busy unchanged.
- R4: Word k of a transfer (k counted from 0) is written to destination + 4*k. Its data is the k-th oldest beat not yet written, so beats are written in the order they were accepted.
- R5: While armed, `s_ready` is high whenever the buffer is not full, until exactly length/4 beats, counting those already held, belong to the transfer.
- R6: On the acknowledge of the last word, busy clears and done sets in the same edge. Done clears when the next length write is accepted.
- R7: Held beats beyond a transfer shorter than the buffer contents stay in the buffer and become the first words of the next transfer.
- R8: `mem_req` stays high with stable `mem_addr` and `mem_wdata` until `mem_ack`. It drops on the edge after the acknowledge, and it is never high while the channel is idle.
- R9: Clearing the run bit while busy holds `s_ready` low and starts no new memory request. A request already raised completes normally, and setting the run bit again resumes the transfer.
- R10: A synchronous reset empties the holding buffer and clears run, busy, done, the destination and the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted when high with `s_valid` |
| s_data | input | 32 | Stream beat data |
| mem_req | output | 1 | Memory word write request |
| mem_addr | output | 32 | Memory byte address of the word |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |

## Verification
A register write becomes visible on `reg_rdata` and on `s_ready` in the cycle after the edge that takes it. The first `mem_req` rises one edge after the channel is armed with a non-empty buffer. Each following request rises two edges after the previous acknowledge, and done is readable in the cycle after the last acknowledge. The bench drives inputs just after a rising edge and samples every output at the falling edge, which is the value the next rising edge acts on. A handshake is recorded only on the edge where both sides were seen high. Waits for completion poll the status register instead of assuming a fixed latency, because memory acknowledges arrive after random delays.

// File: rtl/s2mm_write_channel.sv
`timescale 1ns/1ps
module s2mm_write_channel #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int LEN_W = 16,
  parameter int DEPTH = 4,
  parameter int RA_W = 8,
  parameter logic [RA_W-1:0] CTRL_OFS = 8'h30,
  parameter logic [RA_W-1:0] STAT_OFS = 8'h34,
  parameter logic [RA_W-1:0] DEST_OFS = 8'h48,
  parameter logic [RA_W-1:0] LEN_OFS  = 8'h58
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr_en,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [DW-1:0]   s_data,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = LEN_W - 2;

  logic            run, busy, done;
  logic [AW-1:0]   dest;
  logic [LEN_W-1:0] len_q;
  logic [WW-1:0]   wr_rem, acc_rem, idx;
  logic [DW-1:0]   buf_q [DEPTH];
  logic [PW-1:0]   rd_p, wr_p;
  logic [CW-1:0]   cnt;
  logic            full, empty, push, pop, len_wr, arm;
  logic [WW-1:0]   words_in, held;
  logic            unused_bits;

  assign full      = cnt == CW'(DEPTH);
  assign empty     = cnt == '0;
  assign s_ready   = !full && (!busy || (run && acc_rem != '0));
  assign push      = s_valid && s_ready;
  assign pop       = mem_req && mem_ack;
  assign len_wr    = reg_wr_en && reg_addr == LEN_OFS;
  assign words_in  = reg_wdata[LEN_W-1:2];
  assign held      = WW'(cnt) + WW'(push);
  assign arm       = len_wr && run && !busy && words_in != '0;
  assign mem_wdata = buf_q[rd_p];
  assign mem_addr  = dest + (AW'(idx) << 2);
  assign unused_bits = ^reg_wdata;

  always_ff @(posedge clk)
    if (push) buf_q[wr_p] <= s_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      if (pop)  rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      dest    <= '0;
      len_q   <= '0;
      wr_rem  <= '0;
      acc_rem <= '0;
      idx     <= '0;
      mem_req <= 1'b0;
    end else begin
      if (reg_wr_en && reg_addr == CTRL_OFS) run <= reg_wdata[0];
      if (reg_wr_en && reg_addr == DEST_OFS) dest <= {reg_wdata[AW-1:2], 2'b00};
      if (arm) begin
        len_q   <= reg_wdata[LEN_W-1:0];
        busy    <= 1'b1;
        done    <= 1'b0;
        wr_rem  <= words_in;
        idx     <= '0;
        acc_rem <= (words_in > held) ? words_in - held : '0;
      end else if (busy) begin
        if (push) acc_rem <= acc_rem - 1'b1;
        if (pop) begin
          idx    <= idx + 1'b1;
          wr_rem <= wr_rem - 1'b1;
          if (wr_rem == WW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
      if (pop) mem_req <= 1'b0;
      else if (busy && run && !empty && !mem_req) mem_req <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      CTRL_OFS: reg_rdata = {31'b0, run};
      STAT_OFS: reg_rdata = {30'b0, done, busy};
      DEST_OFS: reg_rdata = 32'(dest);
      LEN_OFS:  reg_rdata = 32'(len_q);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/s2mm_write_channel_chk.sv
`timescale 1ns/1ps
module s2mm_write_channel_chk #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 3,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          s_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [CW-1:0] cnt,
  input logic          busy,
  input logic          run,
  input logic          done,
  input logic          len_wr
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1
  buffer_full_chk: assert property (@(posedge clk) disable iff (rst)
    cnt == CW'(DEPTH) |-> !s_ready);

  // R3
  len_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (len_wr && !run && !busy) |=> !busy);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R8
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy);

  // R9
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !run) |-> !s_ready);

  // R9
  no_new_req_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !run && !mem_req) |=> !mem_req);

  // R10
  always @(posedge clk)
    if (rst_d) reset_clear_chk: assert (cnt == '0 && !busy && !done && !run && !mem_req);
endmodule

bind s2mm_write_channel s2mm_write_channel_chk #(
  .DW(DW), .AW(AW), .CW(CW), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .s_ready(s_ready), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cnt(cnt), .busy(busy), .run(run),
  .done(done), .len_wr(len_wr)
);

// File: tb/tb_s2mm_write_channel.sv
`timescale 1ns/1ps
module tb_s2mm_write_channel;
  localparam logic [7:0] CTRL = 8'h30, STAT = 8'h34, DEST = 8'h48, LEN = 8'h58;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;

  s2mm_write_channel dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );

  int tests = 0, fails = 0;
  logic [31:0] acc_q [$];
  logic [31:0] cur_dest = '0;
  int wr_cnt = 0;
  bit hs = 1'b0;
  bit src_en = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int k);
    return {base[31:2], 2'b00} + 32'(k * 4);
  endfunction

  // Monitor: sample at the falling edge the values the next rising edge uses
  always @(negedge clk) begin
    hs = 1'b0;
    if (!rst) begin
      if (s_valid && s_ready) begin
        acc_q.push_back(s_data);
        hs = 1'b1;
      end
      if (mem_req && mem_ack) begin
        if (acc_q.size() == 0) chk(1'b0, "R4", "write with no beat", mem_wdata, 0);
        else begin
          logic [31:0] d;
          d = acc_q.pop_front();
          chk(mem_wdata == d, "R4", "write data", mem_wdata, d);
        end
        chk(mem_addr == exp_addr(cur_dest, wr_cnt), "R4", "write address",
            mem_addr, exp_addr(cur_dest, wr_cnt));
        wr_cnt++;
      end
    end
  end

  // Stream source
  always begin
    @(posedge clk); #2;
    if (!src_en) s_valid = 1'b0;
    else if (hs || !s_valid) begin
      s_valid = ($urandom % 4) != 0;
      s_data  = $urandom;
    end
  end

  // Memory acknowledge with random delay
  always begin
    @(posedge clk); #2;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req && ($urandom % 3) == 0) mem_ack = 1'b1;
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(posedge clk); #2;
    rst = 1'b1;
    cycles(3); #2;
    rst = 1'b0;
    acc_q.delete();
    wr_cnt = 0;
  endtask

  task automatic arm(input logic [31:0] dst, input int words);
    reg_write(DEST, dst);
    cur_dest = dst;
    wr_cnt = 0;
    reg_write(LEN, 32'(words * 4));
  endtask

  task automatic wait_done(input string req);
    logic [31:0] st;
    bit ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      reg_read(STAT, st);
      if (st[1] && !st[0]) begin ok = 1'b1; break; end
    end
    chk(ok, req, "transfer completion", 0, 1);
  endtask

  task automatic settle_check(input string req);
    cycles(30);
    @(negedge clk);
    chk(acc_q.size() == 4, req, "idle buffer level", acc_q.size(), 4);
    chk(s_ready == 1'b0, req, "ready low when idle and full", s_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int seen, words;
    void'($urandom(32'h1d5c));
    do_reset();

    // R10 reset state
    @(negedge clk);
    chk(s_ready == 1'b1, "R10", "ready after reset", s_ready, 1);
    chk(mem_req == 1'b0, "R10", "no request after reset", mem_req, 0);
    reg_read(CTRL, r); chk(r == 0, "R10", "control after reset", r, 0);
    reg_read(STAT, r); chk(r == 0, "R10", "status after reset", r, 0);

    // R1 preload of four beats before setup
    src_en = 1'b1;
    cycles(40);
    @(negedge clk);
    chk(acc_q.size() == 4, "R1", "beats taken before setup", acc_q.size(), 4);
    chk(s_ready == 1'b0, "R1", "ready held low", s_ready, 0);

    // R3 length write ignored while run is clear
    reg_write(LEN, 32'd32);
    reg_read(STAT, r); chk(r[0] == 1'b0, "R3", "busy after ignored length", r[0], 0);
    reg_read(LEN, r);  chk(r == 0, "R3", "length register unchanged", r, 0);
    @(negedge clk);
    chk(s_ready == 1'b0, "R3", "ready after ignored length", s_ready, 0);

    // R2 register readback
    reg_write(DEST, 32'h1000_0003);
    reg_read(DEST, r); chk(r == 32'h1000_0000, "R2", "destination readback", r, 32'h1000_0000);
    reg_write(CTRL, 32'h1);
    reg_read(CTRL, r); chk(r == 1, "R2", "run readback", r, 1);
    reg_read(8'h3c, r); chk(r == 0, "R2", "unmapped offset", r, 0);

    // R4 R5 R6 first transfer, held beats lead
    arm(32'h1000_0000, 8);
    reg_read(STAT, r); chk(r[0] == 1'b1, "R3", "busy after length write", r[0], 1);
    reg_read(LEN, r);  chk(r == 32, "R2", "length readback", r, 32);
    wait_done("R6");
    chk(wr_cnt == 8, "R5", "words written", wr_cnt, 8);
    settle_check("R5");

    // R7 short transfer leaves held beats for the next one
    arm(32'h2000_0100, 2);
    reg_read(STAT, r); chk(r[1] == 1'b0, "R6", "done cleared on arm", r[1], 0);
    wait_done("R7");
    chk(wr_cnt == 2, "R7", "short transfer words", wr_cnt, 2);
    settle_check("R7");
    arm(32'h2000_0200, 3);
    wait_done("R7");
    chk(wr_cnt == 3, "R7", "following transfer words", wr_cnt, 3);
    settle_check("R7");

    // R9 pause by clearing run
    arm(32'h3000_0000, 24);
    while (wr_cnt < 3) @(posedge clk);
    reg_write(CTRL, 32'h0);
    do @(negedge clk); while (mem_req);
    cycles(2);
    seen = wr_cnt;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (s_ready || mem_req) begin
        chk(1'b0, "R9", "activity while run clear", {s_ready, mem_req}, 0);
        break;
      end
    end
    chk(wr_cnt == seen, "R9", "no writes while paused", wr_cnt, seen);
    reg_write(CTRL, 32'h1);
    wait_done("R9");
    chk(wr_cnt == 24, "R9", "resumed transfer words", wr_cnt, 24);
    settle_check("R9");

    // Random transfers (R4 R5 R8)
    for (int t = 0; t < 8; t++) begin
      words = 1 + ($urandom % 20);
      arm({$urandom % 32'h10000, 2'b00}, words);
      wait_done("R8");
      chk(wr_cnt == words, "R8", "random transfer words", wr_cnt, words);
      settle_check("R5");
    end

    // R10 reset in the middle of a transfer
    arm(32'h4000_0000, 16);
    while (wr_cnt < 2) @(posedge clk);
    src_en = 1'b0;
    cycles(2);
    do_reset();
    @(negedge clk);
    chk(s_ready == 1'b1, "R10", "buffer empty after reset", s_ready, 1);
    reg_read(STAT, r); chk(r == 0, "R10", "status cleared", r, 0);
    reg_read(DEST, r); chk(r == 0, "R10", "destination cleared", r, 0);
    reg_read(LEN, r);  chk(r == 0, "R10", "length cleared", r, 0);
    reg_read(CTRL, r); chk(r == 0, "R10", "run cleared", r, 0);
    src_en = 1'b1;
    reg_write(CTRL, 32'h1);
    settle_check("R1");
    arm(32'h5000_0040, 6);
    wait_done("R10");
    chk(wr_cnt == 6, "R10", "post-reset transfer words", wr_cnt, 6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule